// File: doc/BRIEF.md
# Ethernet Receive Deframer

This block sits between a media-independent interface (MII) receiver and the logic that buffers, filters and counts frames. It takes 4-bit receive nibbles, each qualified by a data-valid line and an error line, and advances only on cycles when the receive clock enable is high. It locates the start-of-frame delimiter, discards the preamble and packs nibble pairs into bytes, least significant nibble first. The bytes leave on a stream with a valid strobe and first-byte and last-byte marks.

The block never stores or compares station addresses. After the six destination bytes it presents a 9-bit value taken from the running CRC-32, with a one-cycle qualifier, and it raises broadcast and multicast indications. Downstream logic uses these to index a hash table. When the frame ends, every result of the frame is packed into one 21-bit status word that is announced by a one-cycle pulse. A shared statistics engine can collect that word for many ports at once.

A pass enable decides whether the bytes of a frame are forwarded. Status, hash and address-class outputs are produced either way.

Top module: `eth_rx_deframer`

## Requirements
- R1: Nibbles with value 0x5 before the first 0xD nibble are dropped. After that 0xD, nibble pairs form bytes, with the first nibble of a pair in bits 3:0. The bytes leave on `rx_data` with `rx_valid` high in the order they arrived. `rx_sof` is high only with the first byte and `rx_eof` only with the last byte of the frame, so the last byte leaves only after the data-valid line has dropped.
- R2: For each frame that reached the 0xD nibble, `stat_valid` is high for exactly one clock after the frame ends, and `stat_word` then holds the status word. Bit 20 is false carrier, 19 is aborted preamble, 18 is frame OK, 17 is broadcast, 16 is multicast, 15 is CRC error, 14 is dribble, 13 is code violation, 12 is too long, 11 is too short, and 10:0 are the length.
- R3: Length is the number of whole bytes after the delimiter, frame check sequence included, saturating at 2047. Too short means a length below 64 and too long means a length above 1518.
- R4: The CRC error bit is set unless the LSB-first CRC-32 register holds 0xDEBB20E3 after every byte of the frame. The register starts at all ones and uses polynomial 0xEDB88320.
- R5: The dribble bit is set when an odd number of nibbles followed the delimiter. The unpaired nibble is not counted and not forwarded.
- R6: The code-violation bit is set when the error line is high with data-valid high on any nibble after the delimiter.
- R7: Frame OK is set exactly when the CRC is good, no code violation occurred, and the frame is neither too short nor too long. Dribble does not affect it.
- R8: After the sixth byte, `addr_bcast` goes high if all six destination bytes are 0xFF. `addr_mcast` goes high if bit 0 of the first byte is 1 and the address is not broadcast. Both hold until the next delimiter, and status bits 17 and 16 report the same values. Frames shorter than six bytes report neither.
- R9: When the sixth byte is accepted, `hash_valid` pulses for one clock. `hash_out` then equals bits 8:0 of the bitwise inverse of the CRC register after those six bytes.
- R10: `pass_en` is sampled on the cycle the delimiter is accepted. If it is 0, that frame produces no `rx_valid`, `rx_sof` or `rx_eof`, but still produces status, hash and address-class outputs.
- R11: All inputs are sampled only on clocks with `rx_ce` high. Values on other clocks have no effect.
- R12: Bit 20 records the error line high while data-valid is low. Bit 19 records data-valid dropping before the delimiter. Both accumulate from the previous status word until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_ce | input | 1 | Receive clock enable; inputs sampled when high |
| pass_en | input | 1 | Forward frame bytes when high (sampled at delimiter) |
| mii_dv | input | 1 | Receive data valid |
| mii_er | input | 1 | Receive error |
| mii_d | input | 4 | Receive nibble |
| rx_valid | output | 1 | Byte stream strobe |
| rx_sof | output | 1 | First byte of frame |
| rx_eof | output | 1 | Last byte of frame |
| rx_data | output | 8 | Byte stream data |
| stat_word | output | 21 | Frame status word |
| stat_valid | output | 1 | One-clock qualifier of `stat_word` |
| hash_out | output | 9 | CRC-derived hash of the destination address |
| hash_valid | output | 1 | One-clock qualifier of `hash_out` |
| addr_bcast | output | 1 | Destination is broadcast |
| addr_mcast | output | 1 | Destination is multicast |

## Verification
The assertions assume that every frame delivers its delimiter and data nibbles while data-valid stays high on enabled clocks. They also assume that frames are separated by at least one enabled clock with data-valid low. The stimulus always closes a frame with several idle enabled nibbles, and it changes `pass_en` only between frames. In the divided-enable runs, the stimulus puts inverted data and an inverted valid line on the clocks where the enable is low. This shows that those clocks are ignored without breaking the framing that the assertions rely on.

// File: rtl/eth_rx_pkg.sv
// Shared types and constants for the receive deframer.
// Assumes the LSB-first CRC-32 convention (reflected register).
package eth_rx_pkg;
    localparam int          LEN_W       = 11;
    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
    localparam logic [3:0]  SFD_NIB     = 4'hD;

    typedef enum logic [1:0] {
        AS_IDLE = 2'd0,
        AS_PRE  = 2'd1,
        AS_DATA = 2'd2
    } asm_state_t;

    typedef struct packed {
        logic             false_carrier;
        logic             dv_event;
        logic             rx_ok;
        logic             bcast;
        logic             mcast;
        logic             crc_bad;
        logic             dribble;
        logic             code_viol;
        logic             too_long;
        logic             too_short;
        logic [LEN_W-1:0] len;
    } rx_status_t;

    // Advance the reflected CRC-32 register by one byte, LSB first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r[0] ^ b[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/rx_nib_asm.sv
// Nibble front end: finds the delimiter nibble, pairs nibbles into bytes
// and raises one-clock event pulses. Advances only when ce is high.
// Assumes data-valid stays high from preamble to the last data nibble.
module rx_nib_asm
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       dv,
    input  logic       er,
    input  logic [3:0] d,
    input  logic       en,
    output logic       sfd_stb,
    output logic       byte_stb,
    output logic [7:0] byte_q,
    output logic       end_stb,
    output logic       end_odd,
    output logic       cv_stb,
    output logic       fc_stb,
    output logic       pre_stb,
    output logic       pass_q
);
    asm_state_t st;
    logic [3:0] lo_q;
    logic       half_q;

    // Framing state machine with registered one-clock event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= AS_IDLE;
            lo_q     <= '0;
            half_q   <= 1'b0;
            sfd_stb  <= 1'b0;
            byte_stb <= 1'b0;
            byte_q   <= '0;
            end_stb  <= 1'b0;
            end_odd  <= 1'b0;
            cv_stb   <= 1'b0;
            fc_stb   <= 1'b0;
            pre_stb  <= 1'b0;
            pass_q   <= 1'b0;
        end else begin
            sfd_stb  <= 1'b0;
            byte_stb <= 1'b0;
            end_stb  <= 1'b0;
            cv_stb   <= 1'b0;
            fc_stb   <= 1'b0;
            pre_stb  <= 1'b0;
            if (ce) begin
                case (st)
                    AS_IDLE: begin
                        if (!dv) begin
                            fc_stb <= er;
                        end else if (d == SFD_NIB) begin
                            st      <= AS_DATA;
                            sfd_stb <= 1'b1;
                            pass_q  <= en;
                            half_q  <= 1'b0;
                        end else begin
                            st <= AS_PRE;
                        end
                    end
                    AS_PRE: begin
                        if (!dv) begin
                            st      <= AS_IDLE;
                            pre_stb <= 1'b1;
                        end else if (d == SFD_NIB) begin
                            st      <= AS_DATA;
                            sfd_stb <= 1'b1;
                            pass_q  <= en;
                            half_q  <= 1'b0;
                        end
                    end
                    AS_DATA: begin
                        if (!dv) begin
                            st      <= AS_IDLE;
                            end_stb <= 1'b1;
                            end_odd <= half_q;
                        end else begin
                            cv_stb <= er;
                            if (!half_q) begin
                                lo_q   <= d;
                                half_q <= 1'b1;
                            end else begin
                                byte_q   <= {d, lo_q};
                                byte_stb <= 1'b1;
                                half_q   <= 1'b0;
                            end
                        end
                    end
                    default: st <= AS_IDLE;
                endcase
            end
        end
    end

    AST_BYTE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(ce)) else $error("byte without enable"); // R11
    AST_END_NOT_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_stb && end_stb)) else $error("byte and end together"); // R1
endmodule

// File: rtl/rx_crc32.sv
// Byte-wise CRC-32 engine. Reloads on the delimiter, advances per byte,
// reports residue match and the hash slice of the next register value.
module rx_crc32
    import eth_rx_pkg::*;
#(
    parameter int HASH_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              stb,
    input  logic [7:0]        data,
    output logic              crc_good,
    output logic [HASH_W-1:0] hash_nxt
);
    logic [31:0] crc_q;
    logic [31:0] crc_n;

    // Next register value for the byte now offered.
    always_comb crc_n = crc_byte(crc_q, data);

    // CRC register: preset at the delimiter, advanced on each byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= CRC_INIT;
        else if (init)   crc_q <= CRC_INIT;
        else if (stb)    crc_q <= crc_n;
    end

    assign crc_good = (crc_q == CRC_RESIDUE);
    assign hash_nxt = ~crc_n[HASH_W-1:0];
endmodule

// File: rtl/rx_frame_track.sv
// Per-frame bookkeeping: one-byte holdback for the end mark, byte count,
// address class, hash capture, sticky events and status word assembly.
// Assumes the assembler never raises byte and end pulses together.
module rx_frame_track
    import eth_rx_pkg::*;
#(
    parameter int MIN_LEN  = 64,
    parameter int MAX_LEN  = 1518,
    parameter int DA_BYTES = 6,
    parameter int HASH_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfd_stb,
    input  logic              byte_stb,
    input  logic [7:0]        byte_q,
    input  logic              end_stb,
    input  logic              end_odd,
    input  logic              cv_stb,
    input  logic              fc_stb,
    input  logic              pre_stb,
    input  logic              pass_q,
    input  logic              crc_good,
    input  logic [HASH_W-1:0] hash_nxt,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic [7:0]        out_data,
    output rx_status_t        stat_q,
    output logic              stat_valid,
    output logic [HASH_W-1:0] hash_q,
    output logic              hash_valid,
    output logic              bcast_q,
    output logic              mcast_q
);
    localparam logic [LEN_W-1:0] CNT_MAX  = '1;
    localparam logic [LEN_W-1:0] LAST_DA  = LEN_W'(DA_BYTES - 1);
    localparam logic [LEN_W-1:0] MIN_L    = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_L    = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

    logic [7:0]       held_q;
    logic             have_held;
    logic [LEN_W-1:0] cnt_q;
    logic             cv_seen, fc_seen, pre_seen;
    logic             da_ones, grp_bit;
    logic             last_ones;
    logic             short_f, long_f, ok_f;

    assign last_ones = da_ones && (byte_q == 8'hFF);
    assign short_f   = cnt_q < MIN_L;
    assign long_f    = cnt_q > MAX_L;
    assign ok_f      = crc_good && !cv_seen && !short_f && !long_f;

    // Byte stream with one-byte holdback so the last byte carries the end mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0; have_held <= 1'b0;
            out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0; out_data <= '0;
        end else begin
            out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0;
            if (sfd_stb) begin
                have_held <= 1'b0;
            end else if (byte_stb) begin
                held_q    <= byte_q;
                have_held <= 1'b1;
                if (have_held && pass_q) begin
                    out_valid <= 1'b1;
                    out_data  <= held_q;
                    out_sof   <= (cnt_q == ONE);
                end
            end else if (end_stb) begin
                have_held <= 1'b0;
                if (have_held && pass_q) begin
                    out_valid <= 1'b1;
                    out_data  <= held_q;
                    out_sof   <= (cnt_q == ONE);
                    out_eof   <= 1'b1;
                end
            end
        end
    end

    // Byte counter and in-frame code-violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0; cv_seen <= 1'b0;
        end else if (sfd_stb) begin
            cnt_q <= '0; cv_seen <= 1'b0;
        end else begin
            if (byte_stb && cnt_q != CNT_MAX) cnt_q <= cnt_q + ONE;
            if (cv_stb) cv_seen <= 1'b1;
        end
    end

    // Destination address class and hash capture at the last address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            da_ones <= 1'b0; grp_bit <= 1'b0; bcast_q <= 1'b0; mcast_q <= 1'b0;
            hash_q <= '0; hash_valid <= 1'b0;
        end else begin
            hash_valid <= 1'b0;
            if (sfd_stb) begin
                bcast_q <= 1'b0; mcast_q <= 1'b0;
            end else if (byte_stb && cnt_q <= LAST_DA) begin
                if (cnt_q == '0) begin
                    da_ones <= (byte_q == 8'hFF);
                    grp_bit <= byte_q[0];
                end else begin
                    da_ones <= last_ones;
                end
                if (cnt_q == LAST_DA) begin
                    hash_q     <= hash_nxt;
                    hash_valid <= 1'b1;
                    bcast_q    <= last_ones;
                    mcast_q    <= grp_bit && !last_ones;
                end
            end
        end
    end

    // Sticky between-frame events, cleared when a status word is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_seen <= 1'b0; pre_seen <= 1'b0;
        end else begin
            fc_seen  <= (fc_seen && !end_stb) || fc_stb;
            pre_seen <= (pre_seen && !end_stb) || pre_stb;
        end
    end

    // Status word assembly at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0; stat_valid <= 1'b0;
        end else begin
            stat_valid <= end_stb;
            if (end_stb) begin
                stat_q.false_carrier <= fc_seen;
                stat_q.dv_event      <= pre_seen;
                stat_q.rx_ok         <= ok_f;
                stat_q.bcast         <= bcast_q;
                stat_q.mcast         <= mcast_q;
                stat_q.crc_bad       <= !crc_good;
                stat_q.dribble       <= end_odd;
                stat_q.code_viol     <= cv_seen;
                stat_q.too_long      <= long_f;
                stat_q.too_short     <= short_f;
                stat_q.len           <= cnt_q;
            end
        end
    end

    AST_GATED_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pass_q)) else $error("byte of blocked frame"); // R10
    AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bcast_q && mcast_q)) else $error("broadcast and multicast"); // R8
endmodule

// File: rtl/eth_rx_deframer.sv
// Top of the receive deframer: nibble front end, CRC engine and frame
// tracker. Assumes frames are separated by an enabled idle nibble.
module eth_rx_deframer
    import eth_rx_pkg::*;
#(
    parameter int MIN_LEN  = 64,
    parameter int MAX_LEN  = 1518,
    parameter int DA_BYTES = 6,
    parameter int HASH_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_ce,
    input  logic              pass_en,
    input  logic              mii_dv,
    input  logic              mii_er,
    input  logic [3:0]        mii_d,
    output logic              rx_valid,
    output logic              rx_sof,
    output logic              rx_eof,
    output logic [7:0]        rx_data,
    output logic [20:0]       stat_word,
    output logic              stat_valid,
    output logic [HASH_W-1:0] hash_out,
    output logic              hash_valid,
    output logic              addr_bcast,
    output logic              addr_mcast
);
    logic              sfd_stb, byte_stb, end_stb, end_odd;
    logic              cv_stb, fc_stb, pre_stb, pass_q;
    logic [7:0]        byte_q;
    logic              crc_good;
    logic [HASH_W-1:0] hash_nxt;
    rx_status_t        stat_q;

    rx_nib_asm u_asm (
        .clk(clk), .rst_n(rst_n), .ce(rx_ce), .dv(mii_dv), .er(mii_er), .d(mii_d),
        .en(pass_en), .sfd_stb(sfd_stb), .byte_stb(byte_stb), .byte_q(byte_q),
        .end_stb(end_stb), .end_odd(end_odd), .cv_stb(cv_stb), .fc_stb(fc_stb),
        .pre_stb(pre_stb), .pass_q(pass_q)
    );

    rx_crc32 #(.HASH_W(HASH_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(sfd_stb), .stb(byte_stb), .data(byte_q),
        .crc_good(crc_good), .hash_nxt(hash_nxt)
    );

    rx_frame_track #(
        .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .DA_BYTES(DA_BYTES), .HASH_W(HASH_W)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .sfd_stb(sfd_stb), .byte_stb(byte_stb),
        .byte_q(byte_q), .end_stb(end_stb), .end_odd(end_odd), .cv_stb(cv_stb),
        .fc_stb(fc_stb), .pre_stb(pre_stb), .pass_q(pass_q), .crc_good(crc_good),
        .hash_nxt(hash_nxt), .out_valid(rx_valid), .out_sof(rx_sof),
        .out_eof(rx_eof), .out_data(rx_data), .stat_q(stat_q),
        .stat_valid(stat_valid), .hash_q(hash_out), .hash_valid(hash_valid),
        .bcast_q(addr_bcast), .mcast_q(addr_mcast)
    );

    assign stat_word = stat_q;

    AST_SOF_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof || rx_eof) |-> rx_valid) else $error("mark without strobe"); // R1
    AST_STAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid) else $error("status pulse too long"); // R2
    AST_HASH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hash_valid |=> !hash_valid) else $error("hash pulse too long"); // R9
    AST_LEN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> !(stat_word[12] && stat_word[11])) else $error("short and long"); // R3
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_word[18]) |-> !(stat_word[15] || stat_word[13] || stat_word[12] || stat_word[11]))
        else $error("ok with fault"); // R7
endmodule

// File: tb/eth_rx_deframer_test.sv
module eth_rx_deframer_test;
    localparam int CLK_P = 10;
    localparam int CAP_N = 8192;

    logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, pen = 1'b1, dv = 1'b0, er = 1'b0;
    logic [3:0] d = '0;
    logic rx_valid, rx_sof, rx_eof, stat_valid, hash_valid, addr_bcast, addr_mcast;
    logic [7:0] rx_data;
    logic [20:0] stat_word;
    logic [8:0] hash_out;

    eth_rx_deframer uut (
        .clk(clk), .rst_n(rst_n), .rx_ce(ce), .pass_en(pen), .mii_dv(dv),
        .mii_er(er), .mii_d(d), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .stat_word(stat_word),
        .stat_valid(stat_valid), .hash_out(hash_out), .hash_valid(hash_valid),
        .addr_bcast(addr_bcast), .addr_mcast(addr_mcast)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, errors = 0, div = 1;
    logic [7:0] fr  [0:2047];
    logic [7:0] cap [0:CAP_N-1];
    int ncap = 0, nsof = 0, neof = 0, sof_pos = -1, eof_pos = -1, nstat = 0, nhash = 0;
    logic [20:0] stat_cap = '0;
    logic [8:0]  hash_cap = '0;

    // Output monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            if (ncap < CAP_N) cap[ncap] = rx_data;
            if (rx_sof) begin sof_pos = ncap; nsof++; end
            if (rx_eof) begin eof_pos = ncap; neof++; end
            ncap++;
        end
        if (stat_valid) begin stat_cap = stat_word; nstat++; end
        if (hash_valid) begin hash_cap = hash_out; nhash++; end
    end

    function automatic logic [31:0] bcrc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ b[i]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One nibble per enable period; off-enable clocks carry inverted junk (R11).
    task automatic nib(input logic v, input logic e, input logic [3:0] x);
        for (int k = 0; k < div; k++) begin
            @(negedge clk);
            if (k == div - 1) begin dv = v; er = e; d = x; ce = 1'b1; end
            else              begin dv = ~v; er = 1'b0; d = ~x; ce = 1'b0; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) nib(1'b0, 1'b0, 4'h0);
    endtask

    // kind: 0 broadcast, 1 multicast, 2 unicast destination
    task automatic send(input int n, input int kind, input bit bad, input bit drib,
                        input int er_at, input bit ena, input bit efc, input bit epre,
                        input string tag);
        logic [31:0] c;
        logic [20:0] es;
        logic [8:0]  eh;
        int base_cap, base_sof, base_eof, base_stat, base_hash, mism;
        bit eok, ebc, emc;
        for (int i = 0; i < n - 4; i++) begin
            if (i < 6) begin
                case (kind)
                    0:       fr[i] = 8'hFF;
                    1:       fr[i] = (i == 0) ? 8'h01 : 8'(8'h5E + i);
                    default: fr[i] = (i == 0) ? 8'h02 : 8'(8'h30 + i);
                endcase
            end else begin
                fr[i] = 8'(i * 37 + n);
            end
        end
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n - 4; i++) c = bcrc(c, fr[i]);
        c = ~c;
        for (int k = 0; k < 4; k++) fr[n - 4 + k] = c[8*k +: 8];
        if (bad) fr[n - 1] = fr[n - 1] ^ 8'h01;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) c = bcrc(c, fr[i]);
        eh = ~c[8:0];
        base_cap = ncap; base_sof = nsof; base_eof = neof; base_stat = nstat; base_hash = nhash;
        pen = ena;
        for (int i = 0; i < 15; i++) nib(1'b1, 1'b0, 4'h5);
        nib(1'b1, 1'b0, 4'hD);
        for (int i = 0; i < n; i++) begin
            nib(1'b1, (i == er_at), fr[i][3:0]);
            nib(1'b1, 1'b0, fr[i][7:4]);
        end
        if (drib) nib(1'b1, 1'b0, 4'hA);
        idle(6);
        pen = 1'b1;
        ebc = (n >= 6) && (kind == 0);
        emc = (n >= 6) && (kind == 1);
        eok = !bad && (er_at < 0) && n >= 64 && n <= 1518;
        es  = {efc, epre, eok, ebc, emc, bad, drib, (er_at >= 0), (n > 1518), (n < 64), 11'(n)};
        chk(nstat - base_stat == 1, "R2 status pulse count", 32'(nstat - base_stat), 1);
        chk(stat_cap == es, $sformatf("%s status word n=%0d", tag, n), 32'(stat_cap), 32'(es));
        if (ena) begin
            mism = 0;
            for (int i = 0; i < n; i++)
                if (base_cap + i < CAP_N && cap[base_cap + i] != fr[i]) mism++;
            chk(ncap - base_cap == n && mism == 0, "R1 byte stream count/mismatch",
                32'(ncap - base_cap), 32'(n));
            chk(nsof - base_sof == 1 && sof_pos == base_cap, "R1 first-byte mark",
                32'(sof_pos - base_cap), 0);
            chk(neof - base_eof == 1 && eof_pos == base_cap + n - 1, "R1 last-byte mark",
                32'(eof_pos - base_cap), 32'(n - 1));
        end else begin
            chk(ncap == base_cap && nsof == base_sof && neof == base_eof,
                "R10 blocked frame emitted bytes", 32'(ncap - base_cap), 0);
        end
        if (n >= 6) begin
            chk(nhash - base_hash == 1 && hash_cap == eh, "R9 hash value",
                32'(hash_cap), 32'(eh));
        end else begin
            chk(nhash == base_hash, "R9 no hash below six bytes", 32'(nhash - base_hash), 0);
        end
        chk(addr_bcast == ebc && addr_mcast == emc, "R8 address class outputs",
            {30'd0, addr_bcast, addr_mcast}, {30'd0, ebc, emc});
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_valid && !stat_valid && !hash_valid && stat_word == '0 && !addr_bcast && !addr_mcast,
            "R2 reset state", {11'd0, stat_word}, 0);
        idle(2);
        // Length boundary sweep over all three address classes (R3, R7, R8).
        for (int n = 60; n <= 68; n++) send(n, n % 3, 0, 0, -1, 1, 0, 0, "R3 R7");
        // Divided clock enable with junk on off-enable clocks (R11).
        div = 4;
        send(64, 1, 0, 0, -1, 1, 0, 0, "R11");
        send(71, 2, 0, 1, -1, 1, 0, 0, "R11 R5");
        div = 1;
        // Upper length boundary (R3).
        for (int n = 1517; n <= 1519; n++) send(n, 2, 0, 0, -1, 1, 0, 0, "R3 long");
        send(80, 0, 1, 0, -1, 1, 0, 0, "R4 crc");
        send(72, 2, 0, 1, -1, 1, 0, 0, "R5 dribble");
        send(90, 1, 0, 0, 40, 1, 0, 0, "R6 violation");
        send(66, 0, 0, 0, -1, 0, 0, 0, "R10 blocked");
        send(5, 2, 0, 0, -1, 1, 0, 0, "R3 R8 tiny");
        // Aborted preamble and false carrier before a frame (R12).
        for (int i = 0; i < 4; i++) nib(1'b1, 1'b0, 4'h5);
        idle(2);
        nib(1'b0, 1'b1, 4'hE);
        idle(2);
        send(64, 2, 0, 0, -1, 1, 1, 1, "R12 sticky set");
        send(64, 2, 0, 0, -1, 1, 0, 0, "R12 sticky cleared");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule